// File: doc/BRIEF.md
# Security-Banked Exception Priority Arbiter

This block picks the most urgent of a small set of pending exceptions and decides whether it may interrupt the handler that is currently running. Each exception is held twice, once per security state. Each copy has its own priority level, and each copy can be pending on its own. A level is programmed as a few bits. It becomes an 8-bit effective priority in which a lower number means more urgent.

A remap bit sits in a control register that only the secure state can write, and only when the write carries a key. When the bit is set, every non-secure effective priority is pushed into the less urgent half of the range. Secure code uses this to keep non-secure handlers from starving its own. The winner is compared with the active priority. A preempt request, the winner's identity and its effective priority leave the block through registers.

Top module: `sec_prio_arb`

## Requirements
- R1: A priority write takes the level from wr_data[7:6] and ignores all other data bits. The level becomes effective priority level<<6, and secure copies always use this value.
- R2: While the remap bit is set, a non-secure effective priority is (level<<6 >> 1) | 0x80. While the bit is clear, the non-secure value is level<<6.
- R3: Addresses 0..NUM_EXC-1 select an exception's priority. wr_ns selects the copy: 0 writes the secure copy, 1 writes the non-secure copy. A write changes only the selected copy.
- R4: After reset, every priority copy holds level 0 and the remap bit is clear.
- R5: preempt is raised only when the winner's effective priority is strictly less than the active priority. Equal values never preempt.
- R6: With act_valid low, the active priority counts as 0x100, so any pending exception preempts.
- R7: When several pending candidates share the most urgent value, the lowest exception number wins. Within one exception, the secure copy wins over the non-secure copy.
- R8: A write to address NUM_EXC (the control register) loads the remap bit from wr_data[0] only if wr_data[31:16] equals 0x05FA. Any other key leaves the bit unchanged.
- R9: A control write with wr_ns high is ignored.
- R10: The outputs are registered and reflect the pending and active inputs one cycle later. With nothing pending, preempt, sel_valid, sel_id, sel_ns and sel_prio are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ns | input | 1 | Security state of the write (1 = non-secure) |
| wr_addr | input | AW | Register address |
| wr_data | input | 32 | Write data |
| pend_s | input | NUM_EXC | Secure pending requests, one per exception |
| pend_ns | input | NUM_EXC | Non-secure pending requests, one per exception |
| act_valid | input | 1 | A handler is active |
| act_prio | input | 8 | Effective priority of the active handler |
| preempt | output | 1 | Winner may preempt the active handler |
| sel_valid | output | 1 | Some exception is pending |
| sel_id | output | IW | Exception number of the winner |
| sel_ns | output | 1 | Winner is the non-secure copy |
| sel_prio | output | 8 | Effective priority of the winner |

## Verification
The arbiter is driven with single secure requests and single non-secure requests, with both copies of one exception pending, and with every candidate pending at once. The active priority is set equal to the winner, just below it, just above it, and to "none". These cases separate strict from non-strict comparison and show the tie order. A secure level 2 is set against an unwritten non-secure level under remap, and the two compare equal. Control writes with a wrong key and writes from the non-secure side show that the remap bit stays put. Writes to one copy of a bank, and writes that carry extra data bits, are checked by reading the affected effective priority back through the selection outputs.

// File: rtl/sec_prio_arb.sv
module sec_prio_arb #(
  parameter int NUM_EXC   = 2,
  parameter int PRIO_BITS = 2,
  parameter int AW        = 4,
  localparam int IW       = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ns,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [NUM_EXC-1:0] pend_s,
  input  logic [NUM_EXC-1:0] pend_ns,
  input  logic              act_valid,
  input  logic [7:0]        act_prio,
  output logic              preempt,
  output logic              sel_valid,
  output logic [IW-1:0]     sel_id,
  output logic              sel_ns,
  output logic [7:0]        sel_prio
);
  localparam int CTL_ADDR = NUM_EXC;
  localparam int LO = 8 - PRIO_BITS;

  logic [PRIO_BITS-1:0] lvl_s  [NUM_EXC];
  logic [PRIO_BITS-1:0] lvl_ns [NUM_EXC];
  logic                 remap;
  logic [7:0]           eff_s  [NUM_EXC];
  logic [7:0]           eff_ns [NUM_EXC];

  wire ctl_hit = wr_en && !wr_ns && (wr_addr == AW'(CTL_ADDR)) &&
                 (wr_data[31:16] == 16'h05FA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remap <= 1'b0;
      for (int e = 0; e < NUM_EXC; e++) begin
        lvl_s[e]  <= '0;
        lvl_ns[e] <= '0;
      end
    end else begin
      if (ctl_hit) remap <= wr_data[0];
      for (int e = 0; e < NUM_EXC; e++) begin
        if (wr_en && wr_addr == AW'(e)) begin
          if (wr_ns) lvl_ns[e] <= wr_data[7:LO];
          else       lvl_s[e]  <= wr_data[7:LO];
        end
      end
    end
  end

  for (genvar e = 0; e < NUM_EXC; e++) begin : g_eff
    wire [7:0] raw_ns = {lvl_ns[e], {LO{1'b0}}};
    assign eff_s[e]  = {lvl_s[e], {LO{1'b0}}};
    assign eff_ns[e] = remap ? {1'b1, raw_ns[7:1]} : raw_ns;
  end

  logic [8:0]    best;
  logic          found;
  logic [IW-1:0] best_id;
  logic          best_ns;

  always_comb begin
    best    = 9'h100;
    found   = 1'b0;
    best_id = '0;
    best_ns = 1'b0;
    for (int e = 0; e < NUM_EXC; e++) begin
      if (pend_s[e] && {1'b0, eff_s[e]} < best) begin
        best = {1'b0, eff_s[e]}; found = 1'b1; best_id = IW'(e); best_ns = 1'b0;
      end
      if (pend_ns[e] && {1'b0, eff_ns[e]} < best) begin
        best = {1'b0, eff_ns[e]}; found = 1'b1; best_id = IW'(e); best_ns = 1'b1;
      end
    end
  end

  wire [8:0] act_eff = act_valid ? {1'b0, act_prio} : 9'h100;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preempt   <= 1'b0;
      sel_valid <= 1'b0;
      sel_id    <= '0;
      sel_ns    <= 1'b0;
      sel_prio  <= '0;
    end else begin
      preempt   <= found && (best < act_eff);
      sel_valid <= found;
      sel_id    <= best_id;
      sel_ns    <= best_ns;
      sel_prio  <= found ? best[7:0] : 8'h00;
    end
  end
endmodule

// File: rtl/sec_prio_arb_chk.sv
module sec_prio_arb_chk #(
  parameter int NUM_EXC   = 2,
  parameter int PRIO_BITS = 2,
  parameter int AW        = 4,
  parameter int IW        = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               wr_ns,
  input logic [AW-1:0]      wr_addr,
  input logic [31:0]        wr_data,
  input logic [NUM_EXC-1:0] pend_s,
  input logic [NUM_EXC-1:0] pend_ns,
  input logic               act_valid,
  input logic [7:0]         act_prio,
  input logic               preempt,
  input logic               sel_valid,
  input logic [IW-1:0]      sel_id,
  input logic               sel_ns,
  input logic [7:0]         sel_prio,
  input logic               remap
);
  localparam int LO = 8 - PRIO_BITS;
  wire ctl_wr = wr_en && (wr_addr == AW'(NUM_EXC));

  logic [NUM_EXC-1:0] ps_q, pn_q;
  always_ff @(posedge clk) begin
    ps_q <= pend_s;
    pn_q <= pend_ns;
  end

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_s == '0 && pend_ns == '0) |=> (!preempt && !sel_valid && sel_prio == 8'h00));

  a_r10_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && $past(rst_n)) |-> (sel_ns ? pn_q[sel_id] : ps_q[sel_id]));

  a_r5_strict: assert property (@(posedge clk) disable iff (!rst_n)
    (preempt && $past(rst_n)) |-> (!$past(act_valid) || sel_prio < $past(act_prio)));

  a_r6_none_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_valid && (pend_s != '0 || pend_ns != '0)) |=> preempt);

  a_r1_secure_align: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !sel_ns) |-> (sel_prio[LO-1:0] == '0));

  a_r2_remap_half: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_ns && $past(remap) && $past(rst_n)) |-> sel_prio[7]);

  a_r8_key: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[31:16] != 16'h05FA) |=> $stable(remap));

  a_r9_ns_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_ns) |=> $stable(remap));
endmodule

bind sec_prio_arb sec_prio_arb_chk #(
  .NUM_EXC(NUM_EXC), .PRIO_BITS(PRIO_BITS), .AW(AW), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ns(wr_ns), .wr_addr(wr_addr),
  .wr_data(wr_data), .pend_s(pend_s), .pend_ns(pend_ns), .act_valid(act_valid),
  .act_prio(act_prio), .preempt(preempt), .sel_valid(sel_valid), .sel_id(sel_id),
  .sel_ns(sel_ns), .sel_prio(sel_prio), .remap(remap)
);

// File: tb/sec_prio_arb_test.sv
module sec_prio_arb_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, wr_ns = 0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  pend_s = '0, pend_ns = '0;
  logic        act_valid = 0;
  logic [7:0]  act_prio = '0;
  logic        preempt, sel_valid, sel_ns;
  logic [0:0]  sel_id;
  logic [7:0]  sel_prio;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  sec_prio_arb uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ns(wr_ns), .wr_addr(wr_addr),
    .wr_data(wr_data), .pend_s(pend_s), .pend_ns(pend_ns), .act_valid(act_valid),
    .act_prio(act_prio), .preempt(preempt), .sel_valid(sel_valid), .sel_id(sel_id),
    .sel_ns(sel_ns), .sel_prio(sel_prio)
  );

  // {pend_s, pend_ns, act_valid, act_prio, preempt, sel_id, sel_ns, sel_prio, sel_valid}
  // config: S0=0x40 S1=0x80, NS0 level0 -> 0x80 under remap, NS1 level3 -> 0xE0
  localparam logic [24:0] VEC [9] = '{
    {2'b01, 2'b00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h40, 1'b1},  // R6
    {2'b10, 2'b00, 1'b1, 8'h80, 1'b0, 1'b1, 1'b0, 8'h80, 1'b1},  // R5 equal
    {2'b10, 2'b00, 1'b1, 8'hC0, 1'b1, 1'b1, 1'b0, 8'h80, 1'b1},  // R5 less
    {2'b00, 2'b01, 1'b1, 8'h80, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1},  // R2 remapped equals secure 2
    {2'b10, 2'b01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1},  // R7 tie -> lowest number
    {2'b00, 2'b10, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 8'hE0, 1'b1},  // R2
    {2'b11, 2'b11, 1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 8'h40, 1'b1},  // R5 all pending
    {2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // R10 idle
    {2'b01, 2'b00, 1'b1, 8'h41, 1'b1, 1'b0, 1'b0, 8'h40, 1'b1}   // R5 one step
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic ns, input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_ns = ns; wr_addr = a; wr_data = d;
    step();
    wr_en = 0; wr_ns = 0;
  endtask

  task automatic apply(input logic [1:0] ps, input logic [1:0] pn,
                       input logic av, input logic [7:0] ap);
    pend_s = ps; pend_ns = pn; act_valid = av; act_prio = ap;
    step();
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    chk("R4 reset outputs", {preempt, sel_valid, sel_ns, sel_prio}, 32'h0);
    apply(2'b00, 2'b01, 1'b0, 8'h00);
    chk("R4 ns level 0 / R6", {preempt, sel_ns, sel_prio}, {1'b1, 1'b1, 8'h00});
    apply(2'b00, 2'b01, 1'b1, 8'h00);
    chk("R5 equal zero no preempt", preempt, 0);

    wr(0, 4'd0, 32'h0000_0040);
    wr(0, 4'd1, 32'h0000_0080);
    wr(1, 4'd1, 32'h0000_00C0);
    apply(2'b00, 2'b10, 1'b0, 8'h00);
    chk("R2 remap clear", sel_prio, 8'hC0);

    wr(0, 4'd2, 32'h05FB_0001);
    apply(2'b00, 2'b01, 1'b0, 8'h00);
    chk("R8 bad key ignored", sel_prio, 8'h00);
    wr(1, 4'd2, 32'h05FA_0001);
    apply(2'b00, 2'b01, 1'b0, 8'h00);
    chk("R9 ns control write ignored", sel_prio, 8'h00);
    wr(0, 4'd2, 32'h05FA_0001);
    apply(2'b00, 2'b01, 1'b0, 8'h00);
    chk("R8 good key sets remap", sel_prio, 8'h80);

    for (int i = 0; i < 9; i++) begin
      apply(VEC[i][24:23], VEC[i][22:21], VEC[i][20], VEC[i][19:12]);
      chk($sformatf("R5/R7 vector %0d", i),
          {preempt, sel_id, sel_ns, sel_prio, sel_valid}, VEC[i][11:0]);
    end

    pend_s = 2'b01; pend_ns = 2'b00; act_valid = 0;
    step();
    pend_s = 2'b00; pend_ns = 2'b10;
    #1;
    chk("R10 output held until edge", sel_prio, 8'h40);
    step();
    chk("R10 output after edge", sel_prio, 8'hE0);

    wr(1, 4'd0, 32'h0000_00C0);
    apply(2'b00, 2'b01, 1'b0, 8'h00);
    chk("R3 ns copy written", sel_prio, 8'hE0);
    apply(2'b01, 2'b00, 1'b0, 8'h00);
    chk("R3 secure copy untouched", sel_prio, 8'h40);

    apply(2'b01, 2'b01, 1'b0, 8'h00);
    chk("R7 secure copy first", {sel_ns, sel_prio}, {1'b0, 8'h40});

    wr(0, 4'd2, 32'h05FA_0000);
    apply(2'b00, 2'b01, 1'b0, 8'h00);
    chk("R2 remap cleared", sel_prio, 8'hC0);

    wr(0, 4'd1, 32'hFFFF_FF3F);
    apply(2'b10, 2'b00, 1'b0, 8'h00);
    chk("R1 only bits 7:6 used", sel_prio, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule